// File: doc/BRIEF.md
# Peripheral Privilege Access Firewall

This block guards a group of up to 64 peripheral slots on behalf of one bus master. Every access arrives with a slot index, a write flag, write data and a privilege bit. Each slot owns a single attribute bit. When that bit marks the slot as privileged-only and the firewall is switched on, an access without privilege is stopped: no read or write strobe goes to the slot, a read gets back zero, the slot index is captured for software, and a sticky fault flag is raised.

Software programs the firewall through a small word-addressed register port. The port holds:

- a control word whose bit 0 switches the firewall on;
- two attribute words;
- a read-only fault index;
- a flag word, plus separate write-one-to-set and write-one-to-clear words for it;
- an interrupt enable word.

The interrupt line is the flag ANDed with the enable. Translating an address into a slot index happens outside this block, and so do the slots themselves.

Top module: `periph_guard`

## Requirements
- R1: A slot whose attribute bit is 1 rejects unprivileged accesses while the firewall is on. A privileged access (m_priv=1) is never rejected. A slot whose bit is 0 accepts both kinds of access.
- R2: Attribute word at cfg_addr 1 bit n governs slot n for n in 0..31. Attribute word at cfg_addr 2 bit n governs slot n+32.
- R3: Control word at cfg_addr 3'd0, bit 0, switches the firewall on. While that bit is 0, no access is rejected and no fault is recorded.
- R4: When an access is accepted, exactly one strobe (p_rd for a read, p_wr for a write) is raised in the same cycle, with p_idx and p_wdata copied from the request. When an access is rejected, neither strobe is raised.
- R5: m_ack pulses in the cycle after each request. m_rdata then carries the slot's p_rdata for an accepted read. It carries all zeros for a rejected read and for any write.
- R6: A rejected access stores its slot index in the fault word (cfg_addr 3, bits [IDX_W-1:0]) on the next cycle. A later rejection overwrites the stored index.
- R7: A rejected access sets flag bit 0 (flag word, cfg_addr 4). Reading the flag word does not clear it.
- R8: irq equals flag bit 0 AND interrupt-enable bit 0 (cfg_addr 7).
- R9: Writing 1 to bit 0 of cfg_addr 5 sets the flag. Writing 1 to bit 0 of cfg_addr 6 clears it. Writing 0 to either leaves the flag as it was. Both of these addresses read as zero.
- R10: After reset, every attribute bit, the control word, the flag, the enable and the fault index are zero.
- R11: If a rejection and a software clear of the flag fall in the same cycle, the flag ends up set.
- R12: A register write takes effect for accesses that start in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req | input | 1 | Master access request, one cycle per access |
| m_write | input | 1 | 1 = write, 0 = read |
| m_priv | input | 1 | 1 = privileged access |
| m_idx | input | IDX_W | Target slot index |
| m_wdata | input | DW | Write data |
| m_ack | output | 1 | Response pulse, one cycle after m_req |
| m_rdata | output | DW | Read data returned with m_ack |
| p_rd | output | 1 | Read strobe to the slot |
| p_wr | output | 1 | Write strobe to the slot |
| p_idx | output | IDX_W | Slot index toward the peripherals |
| p_wdata | output | DW | Write data toward the peripherals |
| p_rdata | input | DW | Read data from the addressed slot |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| irq | output | 1 | Fault interrupt |

## Verification
The bench builds the block with its default parameters: 64 slots and a 32-bit data path. With that configuration both attribute words are fully populated, and the slot indices 31, 32 and 63 can be driven to probe the boundary between the two words. The random phase mixes accesses with attribute, enable, set, clear and interrupt-enable writes. The directed cases cover fault index overwrite, a rejection that coincides with a clear, and a disabled firewall.

// File: rtl/guard_pkg.sv
package guard_pkg;
    localparam int CFG_DW    = 32;
    localparam int FLAG_PRIV = 0;

    typedef enum logic [2:0] {
        CFG_CTRL    = 3'd0,
        CFG_ATTR_LO = 3'd1,
        CFG_ATTR_HI = 3'd2,
        CFG_FAULT   = 3'd3,
        CFG_FLAGS   = 3'd4,
        CFG_FSET    = 3'd5,
        CFG_FCLR    = 3'd6,
        CFG_IEN     = 3'd7
    } cfg_addr_e;
endpackage

// File: rtl/guard_check.sv
module guard_check #(
    parameter int NUM_SLOTS = 64,
    parameter int IDX_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic                 write,
    input  logic                 priv,
    input  logic [IDX_W-1:0]     idx,
    input  logic                 enable,
    input  logic [NUM_SLOTS-1:0] attr,
    output logic                 p_rd,
    output logic                 p_wr,
    output logic                 fault
);
    localparam int SPAN = 1 << IDX_W;

    logic [SPAN-1:0] attr_pad;
    logic            locked;

    // Slots beyond NUM_SLOTS behave as open (attribute zero).
    always_comb begin
        attr_pad                = '0;
        attr_pad[NUM_SLOTS-1:0] = attr;
    end

    always_comb begin
        locked = enable && attr_pad[idx] && !priv;
        fault  = req && locked;
        p_rd   = req && !locked && !write;
        p_wr   = req && !locked && write;
    end

    // R1: privileged traffic always reaches the slot
    assert_priv_passes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req && priv) |-> (p_rd || p_wr));

    // R3: a disabled firewall never rejects
    assert_open_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !enable) |-> !fault);

    // R4: each request has exactly one outcome
    assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $onehot({p_rd, p_wr, fault}));
endmodule

// File: rtl/guard_resp.sv
module guard_resp #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          write,
    input  logic          fault,
    input  logic [DW-1:0] p_rdata,
    output logic          ack,
    output logic [DW-1:0] rdata
);
    typedef struct packed {
        logic          ack;
        logic [DW-1:0] rdata;
    } resp_t;

    resp_t rs_d, rs_q;

    always_comb begin
        rs_d.ack   = req;
        rs_d.rdata = (req && !write && !fault) ? p_rdata : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign ack   = rs_q.ack;
    assign rdata = rs_q.rdata;

    // R5: a rejected read answers with zeros on the following cycle
    assert_blocked_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !write && fault) |=> (ack && rdata == '0));
endmodule

// File: rtl/guard_regs.sv
module guard_regs
    import guard_pkg::*;
#(
    parameter int NUM_SLOTS = 64,
    parameter int IDX_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [2:0]           cfg_addr,
    input  logic [CFG_DW-1:0]    cfg_wdata,
    output logic [CFG_DW-1:0]    cfg_rdata,
    input  logic                 fault_i,
    input  logic [IDX_W-1:0]     fault_idx_i,
    output logic                 enable_o,
    output logic [NUM_SLOTS-1:0] attr_o,
    output logic                 irq_o
);
    localparam int ATTR_BITS = 2 * CFG_DW;
    localparam logic [ATTR_BITS-1:0] ATTR_MASK =
        (NUM_SLOTS >= ATTR_BITS) ? '1 : ((ATTR_BITS'(1) << NUM_SLOTS) - ATTR_BITS'(1));

    typedef struct packed {
        logic                 en;
        logic [ATTR_BITS-1:0] attr;
        logic [IDX_W-1:0]     fidx;
        logic                 flag;
        logic                 ien;
    } regs_t;

    regs_t     st_d, st_q;
    cfg_addr_e sel;
    logic      set_hit, clr_hit;

    assign sel     = cfg_addr_e'(cfg_addr);
    assign set_hit = cfg_wr && (sel == CFG_FSET) && cfg_wdata[FLAG_PRIV];
    assign clr_hit = cfg_wr && (sel == CFG_FCLR) && cfg_wdata[FLAG_PRIV];

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            case (sel)
                CFG_CTRL:    st_d.en                        = cfg_wdata[0];
                CFG_ATTR_LO: st_d.attr[CFG_DW-1:0]          = cfg_wdata;
                CFG_ATTR_HI: st_d.attr[ATTR_BITS-1:CFG_DW]  = cfg_wdata;
                CFG_IEN:     st_d.ien                       = cfg_wdata[FLAG_PRIV];
                default:     ;
            endcase
        end
        st_d.attr = st_d.attr & ATTR_MASK;
        if (set_hit) st_d.flag = 1'b1;
        if (clr_hit) st_d.flag = 1'b0;
        // A hardware fault overrides a software clear in the same cycle.
        if (fault_i) begin
            st_d.flag = 1'b1;
            st_d.fidx = fault_idx_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cfg_rdata = '0;
        case (sel)
            CFG_CTRL:    cfg_rdata[0]            = st_q.en;
            CFG_ATTR_LO: cfg_rdata               = st_q.attr[CFG_DW-1:0];
            CFG_ATTR_HI: cfg_rdata               = st_q.attr[ATTR_BITS-1:CFG_DW];
            CFG_FAULT:   cfg_rdata[IDX_W-1:0]    = st_q.fidx;
            CFG_FLAGS:   cfg_rdata[FLAG_PRIV]    = st_q.flag;
            CFG_IEN:     cfg_rdata[FLAG_PRIV]    = st_q.ien;
            default:     cfg_rdata               = '0;
        endcase
    end

    assign enable_o = st_q.en;
    assign attr_o   = st_q.attr[NUM_SLOTS-1:0];
    assign irq_o    = st_q.flag & st_q.ien;

    // R6: a rejection records its slot index on the next cycle
    assert_fault_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> (st_q.flag && st_q.fidx == $past(fault_idx_i)));

    // R7: the flag only drops on an explicit clear
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !clr_hit) |=> st_q.flag);

    // R11: rejection wins over a coincident clear
    assert_fault_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_i && clr_hit) |=> st_q.flag);
endmodule

// File: rtl/periph_guard.sv
module periph_guard
    import guard_pkg::*;
#(
    parameter int NUM_SLOTS = 64,
    parameter int DW        = 32,
    parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_req,
    input  logic              m_write,
    input  logic              m_priv,
    input  logic [IDX_W-1:0]  m_idx,
    input  logic [DW-1:0]     m_wdata,
    output logic              m_ack,
    output logic [DW-1:0]     m_rdata,
    output logic              p_rd,
    output logic              p_wr,
    output logic [IDX_W-1:0]  p_idx,
    output logic [DW-1:0]     p_wdata,
    input  logic [DW-1:0]     p_rdata,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    output logic              irq
);
    logic                 enable;
    logic [NUM_SLOTS-1:0] attr;
    logic                 fault;

    assign p_idx   = m_idx;
    assign p_wdata = m_wdata;

    guard_regs #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .fault_i    (fault),
        .fault_idx_i(m_idx),
        .enable_o   (enable),
        .attr_o     (attr),
        .irq_o      (irq)
    );

    guard_check #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_check (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (m_req),
        .write (m_write),
        .priv  (m_priv),
        .idx   (m_idx),
        .enable(enable),
        .attr  (attr),
        .p_rd  (p_rd),
        .p_wr  (p_wr),
        .fault (fault)
    );

    guard_resp #(.DW(DW)) u_resp (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (m_req),
        .write  (m_write),
        .fault  (fault),
        .p_rdata(p_rdata),
        .ack    (m_ack),
        .rdata  (m_rdata)
    );
endmodule

// File: tb/sim_periph_guard.sv
module sim_periph_guard;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 6;
    localparam int DW = 32;

    logic             clk = 0;
    logic             rst_n = 0;
    logic             m_req = 0, m_write = 0, m_priv = 0;
    logic [IDX_W-1:0] m_idx = '0;
    logic [DW-1:0]    m_wdata = '0;
    logic             m_ack;
    logic [DW-1:0]    m_rdata;
    logic             p_rd, p_wr;
    logic [IDX_W-1:0] p_idx;
    logic [DW-1:0]    p_wdata;
    logic [DW-1:0]    p_rdata;
    logic             cfg_wr = 0;
    logic [2:0]       cfg_addr = '0;
    logic [31:0]      cfg_wdata = '0;
    logic [31:0]      cfg_rdata;
    logic             irq;

    int total = 0;
    int bad = 0;

    logic        e_en, e_flag, e_ien;
    logic [63:0] e_attr;
    logic [5:0]  e_fidx;

    function automatic logic [31:0] slot_data(input logic [5:0] i);
        return 32'hA500_0000 | (32'(i) * 32'h0000_0101) | 32'h1;
    endfunction

    function automatic logic exp_blocked(input logic [5:0] i, input logic pv);
        return e_en && e_attr[i] && !pv;
    endfunction

    assign p_rdata = slot_data(p_idx);

    always #(CLK_PERIOD/2) clk = ~clk;

    periph_guard u0 (
        .clk(clk), .rst_n(rst_n),
        .m_req(m_req), .m_write(m_write), .m_priv(m_priv), .m_idx(m_idx), .m_wdata(m_wdata),
        .m_ack(m_ack), .m_rdata(m_rdata),
        .p_rd(p_rd), .p_wr(p_wr), .p_idx(p_idx), .p_wdata(p_wdata), .p_rdata(p_rdata),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 0;
        case (a)
            3'd0: e_en = d[0];
            3'd1: e_attr[31:0] = d;
            3'd2: e_attr[63:32] = d;
            3'd5: if (d[0]) e_flag = 1;
            3'd6: if (d[0]) e_flag = 0;
            3'd7: e_ien = d[0];
            default: ;
        endcase
    endtask

    task automatic cfg_check(input string tag, input logic [2:0] a, input logic [31:0] exp);
        cfg_addr = a;
        #1;
        check(tag, cfg_rdata, exp);
    endtask

    task automatic access(input string tag, input logic [5:0] i, input logic wr,
                          input logic pv, input logic [31:0] wd, input logic with_clr);
        logic blk;
        @(negedge clk);
        m_req = 1; m_write = wr; m_priv = pv; m_idx = i; m_wdata = wd;
        if (with_clr) begin cfg_wr = 1; cfg_addr = 3'd6; cfg_wdata = 32'h1; end
        #1;
        blk = exp_blocked(i, pv);
        check({tag, " R4 rd strobe"}, {31'b0, p_rd}, {31'b0, !blk && !wr});
        check({tag, " R4 wr strobe"}, {31'b0, p_wr}, {31'b0, !blk && wr});
        if (!blk) begin
            check({tag, " R4 idx"}, {26'b0, p_idx}, {26'b0, i});
            check({tag, " R4 wdata"}, p_wdata, wd);
        end
        @(negedge clk);
        m_req = 0; cfg_wr = 0;
        check({tag, " R5 ack"}, {31'b0, m_ack}, 32'h1);
        check({tag, " R5 rdata"}, m_rdata, (!wr && !blk) ? slot_data(i) : 32'h0);
        if (with_clr) e_flag = 0;
        if (blk) begin e_flag = 1; e_fidx = i; end
        check({tag, " R8 irq"}, {31'b0, irq}, {31'b0, e_flag & e_ien});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        e_en = 0; e_flag = 0; e_ien = 0; e_attr = '0; e_fidx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R10: reset state
        for (int a = 0; a < 8; a++) cfg_check("R10 reset reg", 3'(a), 32'h0);
        check("R10 irq", {31'b0, irq}, 32'h0);
        check("R10 ack", {31'b0, m_ack}, 32'h0);

        cfg_write(3'd0, 32'h1);
        cfg_check("R3 ctrl readback", 3'd0, 32'h1);
        access("R10 open after reset", 6'd5, 1'b0, 1'b0, 32'h0, 1'b0);
        cfg_check("R10 no fault", 3'd4, 32'h0);

        // R2: attribute word mapping at the 31/32 boundary and top slot
        cfg_write(3'd1, 32'h8000_0000);
        cfg_write(3'd2, 32'h8000_0001);
        cfg_check("R2 lo readback", 3'd1, 32'h8000_0000);
        cfg_check("R2 hi readback", 3'd2, 32'h8000_0001);
        access("R2 slot30", 6'd30, 1'b0, 1'b0, 32'h0, 1'b0);
        access("R2 slot33", 6'd33, 1'b1, 1'b0, 32'h1234, 1'b0);
        access("R2 slot31 R1", 6'd31, 1'b0, 1'b0, 32'h0, 1'b0);
        cfg_check("R6 fidx 31", 3'd3, 32'd31);
        cfg_check("R7 flag set", 3'd4, 32'h1);
        cfg_check("R7 flag kept after read", 3'd4, 32'h1);
        access("R2 slot32", 6'd32, 1'b1, 1'b0, 32'hDEAD, 1'b0);
        cfg_check("R6 overwrite fidx 32", 3'd3, 32'd32);
        access("R2 slot63", 6'd63, 1'b0, 1'b0, 32'h0, 1'b0);
        cfg_check("R6 fidx 63", 3'd3, 32'd63);
        access("R1 priv slot63", 6'd63, 1'b0, 1'b1, 32'h0, 1'b0);
        cfg_check("R6 fidx kept on priv", 3'd3, 32'd63);

        // R8: interrupt gating
        check("R8 irq masked", {31'b0, irq}, 32'h0);
        cfg_write(3'd7, 32'h1);
        check("R8 irq enabled", {31'b0, irq}, 32'h1);

        // R9: set/clear semantics
        cfg_write(3'd6, 32'hFFFF_FFFE);
        cfg_check("R9 clear zero no effect", 3'd4, 32'h1);
        cfg_write(3'd6, 32'h1);
        cfg_check("R9 clear", 3'd4, 32'h0);
        check("R8 irq after clear", {31'b0, irq}, 32'h0);
        cfg_write(3'd5, 32'hFFFF_FFFE);
        cfg_check("R9 set zero no effect", 3'd4, 32'h0);
        cfg_write(3'd5, 32'h1);
        cfg_check("R9 set", 3'd4, 32'h1);
        cfg_check("R9 set word reads zero", 3'd5, 32'h0);
        cfg_check("R9 clr word reads zero", 3'd6, 32'h0);

        // R11: rejection with simultaneous clear
        access("R11 fault vs clear", 6'd31, 1'b0, 1'b0, 32'h0, 1'b1);
        cfg_check("R11 flag stays", 3'd4, 32'h1);
        // accepted access with a clear: flag drops
        access("R11 clear alone", 6'd1, 1'b0, 1'b0, 32'h0, 1'b1);
        cfg_check("R9 cleared with access", 3'd4, 32'h0);

        // R3: disabled firewall
        cfg_write(3'd0, 32'h0);
        access("R3 disabled slot31", 6'd31, 1'b0, 1'b0, 32'h0, 1'b0);
        access("R3 disabled slot63", 6'd63, 1'b1, 1'b0, 32'h55, 1'b0);
        cfg_check("R3 no flag", 3'd4, 32'h0);
        // R12: re-enable takes effect on the next access
        cfg_write(3'd0, 32'h1);
        access("R12 reenabled", 6'd63, 1'b0, 1'b0, 32'h0, 1'b0);
        cfg_check("R12 flag", 3'd4, 32'h1);

        // Constrained random mix
        for (int n = 0; n < 600; n++) begin
            int op;
            op = int'($urandom % 10);
            if (op < 6) begin
                access("R1 rnd", 6'($urandom), 1'($urandom), ($urandom % 3) == 0,
                       $urandom, ($urandom % 8) == 0);
            end else if (op == 6) begin
                cfg_write(($urandom % 2) ? 3'd1 : 3'd2, $urandom);
            end else if (op == 7) begin
                cfg_write(($urandom % 2) ? 3'd5 : 3'd6, $urandom);
            end else if (op == 8) begin
                cfg_write(3'd0, {31'b0, ($urandom % 4) != 0});
            end else begin
                cfg_write(3'd7, $urandom);
            end
            cfg_check("R7 rnd flags", 3'd4, {31'b0, e_flag});
            if (e_flag) cfg_check("R6 rnd fidx", 3'd3, {26'b0, e_fidx});
            check("R8 rnd irq", {31'b0, irq}, {31'b0, e_flag & e_ien});
        end
        cfg_check("R2 rnd lo", 3'd1, e_attr[31:0]);
        cfg_check("R2 rnd hi", 3'd2, e_attr[63:32]);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule